// File: doc/BRIEF.md
# Reset Source Status Register

This block holds an 8-bit status byte that a host reads to learn what caused the most recent system reset. Five event strobes each mark one cause: a cold power-up, the management controller, the front-panel push button, the backplane reset input and the watchdog timer. Each strobe sets its own sticky flag. The host clears a flag by writing a one to its bit position. One further bit is a do-not-log flag. The host can only set it, and only the management-controller side can clear it. While it reads 0, the next reset is logged.

The flags sit in a power-on reset domain, so an ordinary system or bus reset leaves them untouched. Only the read-data register responds to the system reset. The host port is a plain strobe interface. A write takes effect at the next clock edge. A read returns the addressed byte on the cycle after the strobe and has no side effects.

Top module: `rss_status_reg`

## Requirements
- R1: When power-on reset is applied, the byte reads 0x80 (bit 7 set, all other bits 0) and `no_log` is 0. The system reset forces `rd_data` to 0.
- R2: A one-cycle strobe on `evt_cold`, `evt_mgmt`, `evt_button`, `evt_backplane` or `evt_wdog` sets bit 7, 3, 2, 1 or 0 respectively at the next clock edge. The bit then stays set without the strobe.
- R3: A host write to the decoded address with a 1 in bit 7, 3, 2, 1 or 0 clears that bit at the next edge. A 0 in a bit position leaves that bit unchanged.
- R4: When a set strobe and a host write-one clear hit the same bit in the same cycle, the bit ends up set.
- R5: A host write with bit 5 at 1 sets bit 5, and `no_log` follows it. A host write cannot clear bit 5.
- R6: Bits 6 and 4 always read 0, whatever is written.
- R7: Writes to any address other than `BASE_ADDR` (default 0x285) change nothing. A read strobe at any other address returns 0.
- R8: Asserting `sys_rst_n` low leaves all flag contents unchanged.
- R9: `rd_data` shows the byte on the clock cycle after a matching `rd_en`. Repeated reads return the same value and change nothing.
- R10: `mgmt_clr_nolog` clears bit 5 at the next edge. If a host set of bit 5 arrives in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst_n | input | 1 | Asynchronous system/bus reset, active low; acts on the read register only |
| addr | input | ADDR_W (16) | Host address |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Registered read data |
| evt_cold | input | 1 | Cold power-up cause strobe |
| evt_mgmt | input | 1 | Management-controller reset cause strobe |
| evt_button | input | 1 | Front-panel button reset cause strobe |
| evt_backplane | input | 1 | Backplane reset input cause strobe |
| evt_wdog | input | 1 | Watchdog reset cause strobe |
| mgmt_clr_nolog | input | 1 | Management-side clear of the do-not-log flag |
| no_log | output | 1 | Current do-not-log flag (bit 5) |

## Verification
An event strobe or a host write presented in cycle N updates the flag at the edge that ends cycle N. The flag is then visible on `no_log` at once and on `rd_data` after one further edge, once a read strobe has been issued. The bench drives every input on the falling clock edge. It holds a read strobe for exactly one rising edge and samples `rd_data` at the next falling edge, so each check lands in the cycle where the registered value is already settled. Expected bytes come from a model in the bench that applies the set, clear and reserved-bit rules.

// File: rtl/rss_pkg.sv
package rss_pkg;
  localparam int DATA_W  = 8;
  localparam int NUM_W1C = 5;

  localparam int BIT_COLD  = 7;
  localparam int BIT_NOLOG = 5;
  localparam int BIT_MGMT  = 3;
  localparam int BIT_BTN   = 2;
  localparam int BIT_BKP   = 1;
  localparam int BIT_WDOG  = 0;

  // Map a write-one-to-clear slot to its bit position in the byte.
  function automatic int w1c_pos(input int slot);
    case (slot)
      0:       return BIT_COLD;
      1:       return BIT_MGMT;
      2:       return BIT_BTN;
      3:       return BIT_BKP;
      default: return BIT_WDOG;
    endcase
  endfunction

  // Value a slot takes at power-on.
  function automatic logic w1c_init(input int slot);
    return (slot == 0);
  endfunction

  // Sticky flag: set dominates clear.
  function automatic logic next_w1c(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  // Host-set flag, cleared by the second agent: host set dominates.
  function automatic logic next_hostset(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction
endpackage

// File: rtl/rss_decode.sv
module rss_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0285
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic addr_match;
  assign addr_match = (addr == BASE_ADDR);
  assign wr_hit = wr_en & addr_match;
  assign rd_hit = rd_en & addr_match;
endmodule

// File: rtl/rss_w1c_flag.sv
module rss_w1c_flag
  import rss_pkg::*;
#(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic por_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) q <= INIT;
    else        q <= next_w1c(q, set, clr);
  end

  // R2 / R4: an event sets the flag, even against a clear
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!por_n)
    set |=> q);
  // R3: a clear without an event empties the flag
  a_r3_clear_empties: assert property (@(posedge clk) disable iff (!por_n)
    (clr && !set) |=> !q);
  // R3: no clear and no event keeps the flag
  a_r3_holds: assert property (@(posedge clk) disable iff (!por_n)
    (!clr && !set) |=> $stable(q));
endmodule

// File: rtl/rss_hostset_flag.sv
module rss_hostset_flag
  import rss_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic host_set,
  input  logic agent_clr,
  output logic q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) q <= 1'b0;
    else        q <= next_hostset(q, host_set, agent_clr);
  end

  // R5: host write of one sets the flag
  a_r5_host_sets: assert property (@(posedge clk) disable iff (!por_n)
    host_set |=> q);
  // R10: the management clear empties the flag when the host is not setting it
  a_r10_agent_clears: assert property (@(posedge clk) disable iff (!por_n)
    (agent_clr && !host_set) |=> !q);
  // R5: without the management clear the flag never falls
  a_r5_no_host_clear: assert property (@(posedge clk) disable iff (!por_n)
    !agent_clr |=> !$fell(q));
endmodule

// File: rtl/rss_readback.sv
module rss_readback
  import rss_pkg::*;
(
  input  logic              clk,
  input  logic              sys_rst_n,
  input  logic              por_n,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)  rd_data <= '0;
    else if (rd_hit) rd_data <= status;
    else             rd_data <= '0;
  end

  // R9: a matching read presents the byte one cycle later
  a_r9_read_latency: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_n)
    rd_hit |=> (rd_data == $past(status)));
  // R7: no matching read gives zero
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_n)
    !rd_hit |=> (rd_data == '0));
  // R6: reserved positions never read as one
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_n)
    (rd_data[6] == 1'b0) && (rd_data[4] == 1'b0));
endmodule

// File: rtl/rss_status_reg.sv
module rss_status_reg
  import rss_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0285
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              evt_cold,
  input  logic              evt_mgmt,
  input  logic              evt_button,
  input  logic              evt_backplane,
  input  logic              evt_wdog,
  input  logic              mgmt_clr_nolog,
  output logic              no_log
);
  logic               wr_hit;
  logic               rd_hit;
  logic [NUM_W1C-1:0] evt_vec;
  logic [NUM_W1C-1:0] clr_vec;
  logic [NUM_W1C-1:0] flag_q;
  logic [DATA_W-1:0]  status;
  logic               nolog_set;
  logic               nolog_q;
  logic               unused_wr_bits;

  assign evt_vec = {evt_wdog, evt_backplane, evt_button, evt_mgmt, evt_cold};
  assign unused_wr_bits = ^{wr_data[6], wr_data[4]};

  rss_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
    .addr   (addr),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .wr_hit (wr_hit),
    .rd_hit (rd_hit)
  );

  for (genvar i = 0; i < NUM_W1C; i++) begin : g_flag
    localparam int POS = w1c_pos(i);
    assign clr_vec[i] = wr_hit & wr_data[POS];
    rss_w1c_flag #(.INIT(w1c_init(i))) u_flag (
      .clk   (clk),
      .por_n (por_n),
      .set   (evt_vec[i]),
      .clr   (clr_vec[i]),
      .q     (flag_q[i])
    );
    assign status[POS] = flag_q[i];
  end

  assign nolog_set = wr_hit & wr_data[BIT_NOLOG];

  rss_hostset_flag u_nolog (
    .clk       (clk),
    .por_n     (por_n),
    .host_set  (nolog_set),
    .agent_clr (mgmt_clr_nolog),
    .q         (nolog_q)
  );

  assign status[BIT_NOLOG] = nolog_q;
  assign status[6] = 1'b0;
  assign status[4] = 1'b0;
  assign no_log = nolog_q;

  rss_readback u_readback (
    .clk       (clk),
    .sys_rst_n (sys_rst_n),
    .por_n     (por_n),
    .rd_hit    (rd_hit),
    .status    (status),
    .rd_data   (rd_data)
  );

  // R7: a write elsewhere changes no flag
  a_r7_foreign_write: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !wr_hit && (evt_vec == '0) && !mgmt_clr_nolog) |=> $stable(status));
endmodule

// File: tb/tb_rss_status_reg.sv
module tb_rss_status_reg;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        evt_cold = 0, evt_mgmt = 0, evt_button = 0, evt_backplane = 0, evt_wdog = 0;
  logic        mgmt_clr_nolog = 1'b0;
  logic        no_log;

  int checks = 0;
  int errors = 0;
  logic [7:0] model;
  localparam logic [15:0] A = 16'h0285;

  always #2 clk = ~clk;

  rss_status_reg dut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .evt_cold(evt_cold),
    .evt_mgmt(evt_mgmt), .evt_button(evt_button), .evt_backplane(evt_backplane),
    .evt_wdog(evt_wdog), .mgmt_clr_nolog(mgmt_clr_nolog), .no_log(no_log)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  // bit order of the strobe vector: {wdog, backplane, button, mgmt, cold}
  task automatic pulse(input logic [4:0] e);
    @(negedge clk);
    {evt_wdog, evt_backplane, evt_button, evt_mgmt, evt_cold} = e;
    @(negedge clk);
    {evt_wdog, evt_backplane, evt_button, evt_mgmt, evt_cold} = '0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 rd_data in reset", rd_data, 8'h00);
    @(negedge clk); por_n = 1'b1; sys_rst_n = 1'b1;
    rd(A, v); check("R1 por value", v, 8'h80);
    check("R1 no_log", {7'd0, no_log}, 8'h00);
    model = 8'h80;
  endtask

  task automatic t_events;
    logic [7:0] v;
    wr(A, 8'h80); model = 8'h00;
    rd(A, v); check("R3 cold cleared", v, model);
    pulse(5'b00010); model |= 8'h08; rd(A, v); check("R2 mgmt sets bit3", v, model);
    pulse(5'b00100); model |= 8'h04; rd(A, v); check("R2 button sets bit2", v, model);
    pulse(5'b01000); model |= 8'h02; rd(A, v); check("R2 backplane sets bit1", v, model);
    pulse(5'b10000); model |= 8'h01; rd(A, v); check("R2 wdog sets bit0", v, model);
    pulse(5'b00001); model |= 8'h80; rd(A, v); check("R2 cold sets bit7", v, model);
  endtask

  task automatic t_w1c;
    logic [7:0] v;
    wr(A, 8'h00); rd(A, v); check("R3 write zero no effect", v, model);
    wr(A, 8'h0A); model &= ~8'h0A; rd(A, v); check("R3 partial clear", v, model);
    wr(A, 8'hFF); model = 8'h20; rd(A, v); check("R3 clear all, R5 set bit5", v, model);
    check("R5 no_log high", {7'd0, no_log}, 8'h01);
  endtask

  task automatic t_set_wins;
    logic [7:0] v;
    @(negedge clk); addr = A; wr_data = 8'h04; wr_en = 1'b1; evt_button = 1'b1;
    @(negedge clk); wr_en = 1'b0; evt_button = 1'b0; wr_data = '0;
    model |= 8'h04; rd(A, v); check("R4 set beats clear", v, model);
    wr(A, 8'h04); model &= ~8'h04;
  endtask

  task automatic t_nolog;
    logic [7:0] v;
    wr(A, 8'h00); rd(A, v); check("R5 host cannot clear bit5", v, model);
    @(negedge clk); mgmt_clr_nolog = 1'b1;
    @(negedge clk); mgmt_clr_nolog = 1'b0;
    model &= ~8'h20; check("R10 mgmt clear no_log", {7'd0, no_log}, 8'h00);
    rd(A, v); check("R10 mgmt clear bit5", v, model);
    @(negedge clk); addr = A; wr_data = 8'h20; wr_en = 1'b1; mgmt_clr_nolog = 1'b1;
    @(negedge clk); wr_en = 1'b0; mgmt_clr_nolog = 1'b0;
    model |= 8'h20; check("R10 host set beats clear", {7'd0, no_log}, 8'h01);
  endtask

  task automatic t_reserved;
    logic [7:0] v;
    wr(A, 8'h50); rd(A, v); check("R6 reserved read zero", v, model);
  endtask

  task automatic t_other_addr;
    logic [7:0] v;
    pulse(5'b10001); model |= 8'h81;
    wr(16'h0284, 8'hFF); rd(A, v); check("R7 foreign write ignored", v, model);
    rd(16'h0286, v); check("R7 foreign read zero", v, 8'h00);
  endtask

  task automatic t_sysrst;
    logic [7:0] v;
    @(negedge clk); sys_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 sysrst zeroes rd_data", rd_data, 8'h00);
    sys_rst_n = 1'b1;
    rd(A, v); check("R8 flags survive sysrst", v, model);
  endtask

  task automatic t_read_noside;
    logic [7:0] v;
    rd(A, v); check("R9 repeat read 1", v, model);
    rd(A, v); check("R9 repeat read 2", v, model);
    @(negedge clk); addr = A; rd_en = 1'b1;
    #1 check("R9 not before edge", rd_data, 8'h00);
    @(negedge clk); rd_en = 1'b0; check("R9 one cycle later", rd_data, model);
  endtask

  task automatic t_por_again;
    logic [7:0] v;
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    model = 8'h80; rd(A, v); check("R1 por reinit", v, model);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_events;
    t_w1c;
    t_set_wins;
    t_nolog;
    t_reserved;
    t_other_addr;
    t_sysrst;
    t_read_noside;
    t_por_again;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule